// File: doc/BRIEF.md
# Completion Status Queue with Pop-on-Read Records

This block keeps a short queue of status records for finished transmit events and another for finished receive events. When an event completes, the hardware presents the whole record on a push port. Each record is made of several 16-bit fields. Software reads the fields of the oldest record at separate register addresses. Reading the last field of the transmit or receive record removes that record from its queue, so the next one moves to the head.

The same register bus also reaches an interrupt flag register. Its two lowest bits report that a queue holds at least one record. These bits go low only when software has popped every record. The remaining event flags are set by one-cycle pulses from other event sources and are cleared by writing 1 to them. A mask register selects which flags drive the single interrupt output. A sticky overflow register records a push that arrived while its queue was full.

The bus uses byte addresses, and 16-bit registers sit 2 bytes apart. Byte offsets: 0x00 flags, 0x02 mask, 0x04 overflow. Transmit field i is at 0x20 + 2*i and receive field i is at 0x40 + 2*i. Read data is registered and appears one cycle after the read strobe.

Top module: `esq_top`

## Requirements
- R1: After reset the flag, mask and overflow registers read 0, both queues are empty, every field address reads 0 and `irq_o` is low.
- R2: A push stores the whole record. While a record is at the head, its fields read back at their addresses. Reading any field other than the last one does not change the queue, so the same field reads the same value again.
- R3: A read of the last field address (transmit 0x20 + 2*(TX_FIELDS-1), receive 0x40 + 2*(RX_FIELDS-1)) returns that field and pops the head. Records come out in push order, and each queue holds up to DEPTH records.
- R4: A push that arrives while its queue holds DEPTH records is dropped, even if a pop happens in the same cycle. The drop sets a sticky bit at offset 0x04: bit 0 for transmit, bit 1 for receive. Writing 1 to that bit clears it.
- R5: Every field read from an empty queue returns 0. A pop-read on an empty queue leaves the queue unchanged, so a later push becomes the head.
- R6: Flag bit 0 is high exactly while the transmit queue is non-empty, and flag bit 1 is high exactly while the receive queue is non-empty. Writing to these bits has no effect.
- R7: Event input k sets flag bit 2+k. Writing 1 to that bit clears it and writing 0 leaves it unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.
- R8: The mask register at 0x02 reads back what was written. `irq_o` is high when any flag bit is high and its mask bit is also high.
- R9: Read data appears on `bus_rdata_o` in the cycle after the read strobe. Odd addresses, unused control offsets and field indexes past the record size read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 8 | Register byte address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| tx_push_i | input | 1 | Push a transmit completion record |
| tx_rec_i | input | 16*TX_FIELDS | Transmit record, field i in bits [16*i +: 16] |
| rx_push_i | input | 1 | Push a receive completion record |
| rx_rec_i | input | 16*RX_FIELDS | Receive record, field i in bits [16*i +: 16] |
| evt_i | input | EVT_N | One-cycle event pulses that set flag bits 2 and up |
| irq_o | output | 1 | Masked OR of all flag bits |

## Verification
The bench builds the block with DEPTH 4, three transmit fields, five receive fields and four event sources. With these small records, a full transmit record and a full receive record fit in a few bus reads. A fifth push in a row then reaches the full-queue drop. The two record sizes also put the pop address at a different field index in each queue, so a pop wired to the wrong index shows up. With four event sources, the flag register spans bits 0 to 5, which leaves unused bit positions to test around the event flags.

// File: rtl/esq_pkg.sv
// Package: shared constants of the completion status queue.
// Byte address = {window[2:0], index[3:0], 1'b0}; odd addresses hit nothing.
package esq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    // Address window selected by bus_addr[7:5]
    localparam logic [2:0] WIN_CTRL = 3'd0;
    localparam logic [2:0] WIN_TX   = 3'd1;
    localparam logic [2:0] WIN_RX   = 3'd2;

    // Register index inside the control window (bus_addr[4:1])
    localparam logic [3:0] IDX_FLAGS = 4'd0;
    localparam logic [3:0] IDX_MASK  = 4'd1;
    localparam logic [3:0] IDX_OVF   = 4'd2;

    // Flag bit positions that are not event driven
    localparam int FLAG_TX_PEND = 0;
    localparam int FLAG_RX_PEND = 1;
    localparam int FLAG_EVT_LSB = 2;
endpackage

// File: rtl/esq_fifo.sv
// Module: esq_fifo
// What it does: keeps up to DEPTH records of FIELDS 16-bit words in arrival
// order and shows the oldest one on head_o (all zero while empty).
// Assumes: push is dropped when the queue is full at the start of the cycle,
// and a pop on an empty queue is ignored.
module esq_fifo #(
    parameter int DEPTH  = 4,
    parameter int FIELDS = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_i,
    input  logic [FIELDS*esq_pkg::DATA_W-1:0] push_rec_i,
    input  logic                          pop_i,
    output logic [FIELDS*esq_pkg::DATA_W-1:0] head_o,
    output logic [$clog2(DEPTH+1)-1:0]    cnt_o,
    output logic                          drop_o
);
    localparam int REC_W = FIELDS * esq_pkg::DATA_W;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [REC_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy status and accepted operations
    always_comb begin
        full    = (cnt == CNT_W'(DEPTH));
        empty   = (cnt == '0);
        do_push = push_i && !full;
        do_pop  = pop_i && !empty;
    end

    // Record storage written at the write pointer
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_rec_i;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Head view, forced to zero when nothing is queued
    always_comb begin
        head_o = empty ? '0 : mem[rd_ptr];
        cnt_o  = cnt;
        drop_o = push_i && full;
    end
endmodule

// File: rtl/esq_flags.sv
// Module: esq_flags
// What it does: holds the write-1-to-clear event flags and the sticky
// overflow bits; a set in the same cycle as a clear wins.
// Assumes: clear vectors are already qualified by the bus write decode.
module esq_flags #(
    parameter int EVT_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_set_i,
    input  logic [EVT_N-1:0] evt_clr_i,
    input  logic [1:0]       ovf_set_i,
    input  logic [1:0]       ovf_clr_i,
    output logic [EVT_N-1:0] evt_flag_o,
    output logic [1:0]       ovf_o
);
    logic [EVT_N-1:0] evt_q;
    logic [1:0]       ovf_q;

    // Event flags: clear selected bits, then apply new sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_q & ~evt_clr_i) | evt_set_i;
        end
    end

    // Sticky overflow bits: same set-over-clear rule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else begin
            ovf_q <= (ovf_q & ~ovf_clr_i) | ovf_set_i;
        end
    end

    assign evt_flag_o = evt_q;
    assign ovf_o      = ovf_q;
endmodule

// File: rtl/esq_top.sv
// Module: esq_top
// What it does: register front end of two pop-on-read completion queues
// (transmit and receive), an interrupt flag register, a mask register and
// sticky overflow bits. Reading the last field of a record pops it.
// Assumes: 16-bit registers at even byte addresses; read data registered;
// TX_FIELDS and RX_FIELDS at most 16; EVT_N at most 14.
module esq_top #(
    parameter int DEPTH     = 4,
    parameter int TX_FIELDS = 6,
    parameter int RX_FIELDS = 11,
    parameter int EVT_N     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              bus_addr_i,
    input  logic                    bus_rd_i,
    input  logic                    bus_wr_i,
    input  logic [15:0]             bus_wdata_i,
    output logic [15:0]             bus_rdata_o,
    input  logic                    tx_push_i,
    input  logic [TX_FIELDS*16-1:0] tx_rec_i,
    input  logic                    rx_push_i,
    input  logic [RX_FIELDS*16-1:0] rx_rec_i,
    input  logic [EVT_N-1:0]        evt_i,
    output logic                    irq_o
);
    import esq_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [3:0] TX_LAST = 4'(TX_FIELDS - 1);
    localparam logic [3:0] RX_LAST = 4'(RX_FIELDS - 1);

    logic [2:0]              win;
    logic [3:0]              idx;
    logic                    even;
    logic                    sel_flags;
    logic                    sel_mask;
    logic                    sel_ovf;
    logic                    tx_pop;
    logic                    rx_pop;
    logic [TX_FIELDS*16-1:0] tx_head;
    logic [RX_FIELDS*16-1:0] rx_head;
    logic [CNT_W-1:0]        tx_cnt;
    logic [CNT_W-1:0]        rx_cnt;
    logic                    tx_drop;
    logic                    rx_drop;
    logic [EVT_N-1:0]        evt_flag;
    logic [EVT_N-1:0]        evt_clr;
    logic [1:0]              ovf_q;
    logic [1:0]              ovf_clr;
    logic [15:0]             mask_q;
    logic [15:0]             flag_vec;
    logic [15:0]             rd_val;

    // Address split and register select
    always_comb begin
        win       = bus_addr_i[7:5];
        idx       = bus_addr_i[4:1];
        even      = !bus_addr_i[0];
        sel_flags = even && (win == WIN_CTRL) && (idx == IDX_FLAGS);
        sel_mask  = even && (win == WIN_CTRL) && (idx == IDX_MASK);
        sel_ovf   = even && (win == WIN_CTRL) && (idx == IDX_OVF);
        tx_pop    = bus_rd_i && even && (win == WIN_TX) && (idx == TX_LAST);
        rx_pop    = bus_rd_i && even && (win == WIN_RX) && (idx == RX_LAST);
    end

    // Write-1-to-clear vectors from the bus
    always_comb begin
        evt_clr = (bus_wr_i && sel_flags) ? bus_wdata_i[FLAG_EVT_LSB +: EVT_N] : '0;
        ovf_clr = (bus_wr_i && sel_ovf)   ? bus_wdata_i[1:0] : 2'b00;
    end

    esq_fifo #(.DEPTH(DEPTH), .FIELDS(TX_FIELDS)) tx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(tx_push_i), .push_rec_i(tx_rec_i), .pop_i(tx_pop),
        .head_o(tx_head), .cnt_o(tx_cnt), .drop_o(tx_drop)
    );

    esq_fifo #(.DEPTH(DEPTH), .FIELDS(RX_FIELDS)) rx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_push_i), .push_rec_i(rx_rec_i), .pop_i(rx_pop),
        .head_o(rx_head), .cnt_o(rx_cnt), .drop_o(rx_drop)
    );

    esq_flags #(.EVT_N(EVT_N)) flags_i (
        .clk(clk), .rst_n(rst_n),
        .evt_set_i(evt_i), .evt_clr_i(evt_clr),
        .ovf_set_i({rx_drop, tx_drop}), .ovf_clr_i(ovf_clr),
        .evt_flag_o(evt_flag), .ovf_o(ovf_q)
    );

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (bus_wr_i && sel_mask) begin
            mask_q <= bus_wdata_i;
        end
    end

    // Flag register view: queue-pending bits plus event flags
    always_comb begin
        flag_vec = '0;
        flag_vec[FLAG_TX_PEND] = (tx_cnt != '0);
        flag_vec[FLAG_RX_PEND] = (rx_cnt != '0);
        flag_vec[FLAG_EVT_LSB +: EVT_N] = evt_flag;
    end

    // Masked interrupt request
    assign irq_o = |(flag_vec & mask_q);

    // Read value selection across the three windows
    always_comb begin
        rd_val = '0;
        if (even) begin
            case (win)
                WIN_CTRL: begin
                    if (idx == IDX_FLAGS)     rd_val = flag_vec;
                    else if (idx == IDX_MASK) rd_val = mask_q;
                    else if (idx == IDX_OVF)  rd_val = {14'd0, ovf_q};
                end
                WIN_TX: begin
                    for (int i = 0; i < TX_FIELDS; i++) begin
                        if (idx == 4'(i)) rd_val = tx_head[i*16 +: 16];
                    end
                end
                WIN_RX: begin
                    for (int i = 0; i < RX_FIELDS; i++) begin
                        if (idx == 4'(i)) rd_val = rx_head[i*16 +: 16];
                    end
                end
                default: rd_val = '0;
            endcase
        end
    end

    // Registered read data, updated on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
        end else if (bus_rd_i) begin
            bus_rdata_o <= rd_val;
        end
    end
endmodule

// File: rtl/esq_chk.sv
// Module: esq_chk
// What it does: concurrent checks on queue occupancy, overflow and flag
// behaviour of esq_top; attached by the bind at the end of this file.
module esq_chk #(
    parameter int DEPTH     = 4,
    parameter int TX_FIELDS = 6,
    parameter int RX_FIELDS = 11,
    parameter int EVT_N     = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [7:0]                 bus_addr_i,
    input logic                       bus_rd_i,
    input logic                       bus_wr_i,
    input logic [15:0]                bus_wdata_i,
    input logic                       tx_push_i,
    input logic                       rx_push_i,
    input logic [EVT_N-1:0]           evt_i,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic [1:0]                 ovf_q,
    input logic [EVT_N-1:0]           evt_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [7:0] TX_POP_ADDR = 8'(8'h20 + 2 * (TX_FIELDS - 1));
    localparam logic [7:0] RX_POP_ADDR = 8'(8'h40 + 2 * (RX_FIELDS - 1));

    // R4
    tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_i && tx_cnt == CNT_W'(DEPTH)) |=> ovf_q[0]);

    // R4
    rx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_i && rx_cnt == CNT_W'(DEPTH)) |=> ovf_q[1]);

    // R3
    tx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_i |=> (tx_cnt <= CNT_W'(DEPTH)));

    // R3
    rx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_i |=> (rx_cnt <= CNT_W'(DEPTH)));

    // R5
    tx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == TX_POP_ADDR && tx_cnt == '0 && !tx_push_i)
        |=> (tx_cnt == '0));

    // R5
    rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == RX_POP_ADDR && rx_cnt == '0 && !rx_push_i)
        |=> (rx_cnt == '0));

    // R7
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((evt_flag & $past(evt_i)) == $past(evt_i)));

    // R7
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 8'h00 && ((bus_wdata_i[2 +: EVT_N] & ~evt_i) != '0))
        |=> ((evt_flag & $past(bus_wdata_i[2 +: EVT_N] & ~evt_i)) == '0));
endmodule

bind esq_top esq_chk #(
    .DEPTH(DEPTH), .TX_FIELDS(TX_FIELDS), .RX_FIELDS(RX_FIELDS), .EVT_N(EVT_N)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .tx_push_i(tx_push_i), .rx_push_i(rx_push_i),
    .evt_i(evt_i), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ovf_q(ovf_q),
    .evt_flag(evt_flag)
);

// File: tb/esq_top_tb_top.sv
// Directed bench for esq_top: one task per scenario, each checking itself.
module esq_top_tb_top;
    localparam int DEPTH = 4;
    localparam int TXF   = 3;
    localparam int RXF   = 5;
    localparam int EVN   = 4;
    localparam logic [7:0] TX_POP = 8'h20 + 8'(2 * (TXF - 1));
    localparam logic [7:0] RX_POP = 8'h40 + 8'(2 * (RXF - 1));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              tx_push = 1'b0;
    logic [TXF*16-1:0] tx_rec = '0;
    logic              rx_push = 1'b0;
    logic [RXF*16-1:0] rx_rec = '0;
    logic [EVN-1:0]    evt = '0;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    esq_top #(.DEPTH(DEPTH), .TX_FIELDS(TXF), .RX_FIELDS(RXF), .EVT_N(EVN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr_i(bus_addr), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .tx_push_i(tx_push), .tx_rec_i(tx_rec),
        .rx_push_i(rx_push), .rx_rec_i(rx_rec),
        .evt_i(evt), .irq_o(irq)
    );

    function automatic logic [15:0] txw(input int n, input int f);
        return {4'hA, 4'(n), 8'(f)};
    endfunction

    function automatic logic [15:0] rxw(input int n, input int f);
        return {4'h5, 4'(n), 8'(f)};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic push_tx(input int n);
        @(negedge clk);
        for (int f = 0; f < TXF; f++) tx_rec[f*16 +: 16] = txw(n, f);
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input int n);
        @(negedge clk);
        for (int f = 0; f < RXF; f++) rx_rec[f*16 +: 16] = rxw(n, f);
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pulse(input logic [EVN-1:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(8'h00, d); chk("R1 flags", d, 16'h0000);
        rd(8'h02, d); chk("R1 mask", d, 16'h0000);
        rd(8'h04, d); chk("R1 overflow", d, 16'h0000);
        rd(8'h20, d); chk("R1 tx field0", d, 16'h0000);
        rd(8'h40, d); chk("R1 rx field0", d, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_tx_order();
        logic [15:0] d;
        for (int n = 0; n < 3; n++) push_tx(n);
        rd(8'h00, d); chk("R6 tx pending", d, 16'h0001);
        for (int n = 0; n < 3; n++) begin
            rd(8'h20, d); chk("R2 tx field0", d, txw(n, 0));
            rd(8'h20, d); chk("R2 tx field0 reread", d, txw(n, 0));
            rd(8'h22, d); chk("R2 tx field1", d, txw(n, 1));
            rd(TX_POP, d); chk("R3 tx pop field", d, txw(n, TXF - 1));
        end
        rd(8'h00, d); chk("R6 tx drained", d, 16'h0000);
        push_tx(7);
        wr(8'h00, 16'h0003);
        rd(8'h00, d); chk("R6 w1 ignored on pending", d, 16'h0001);
        rd(8'h26, d); chk("R9 tx index past record", d, 16'h0000);
        rd(8'h21, d); chk("R9 odd address", d, 16'h0000);
        rd(TX_POP, d); chk("R3 tx pop after write", d, txw(7, TXF - 1));
    endtask

    task automatic t_rx_overflow();
        logic [15:0] d;
        for (int n = 0; n < DEPTH + 1; n++) push_rx(n);
        rd(8'h04, d); chk("R4 rx overflow bit", d, 16'h0002);
        rd(8'h00, d); chk("R6 rx pending", d, 16'h0002);
        for (int n = 0; n < DEPTH; n++) begin
            rd(8'h46, d); chk("R2 rx field3", d, rxw(n, 3));
            rd(RX_POP, d); chk("R3 rx pop order", d, rxw(n, RXF - 1));
        end
        rd(RX_POP, d); chk("R4 dropped record absent", d, 16'h0000);
        rd(8'h00, d); chk("R6 rx drained", d, 16'h0000);
        rd(8'h04, d); chk("R4 overflow sticky", d, 16'h0002);
        wr(8'h04, 16'h0002);
        rd(8'h04, d); chk("R4 overflow cleared", d, 16'h0000);
        for (int n = 0; n < DEPTH; n++) push_tx(n);
        @(negedge clk);
        bus_addr = TX_POP; bus_rd = 1'b1;
        for (int f = 0; f < TXF; f++) tx_rec[f*16 +: 16] = txw(9, f);
        tx_push = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; tx_push = 1'b0;
        chk("R3 pop while full", bus_rdata, txw(0, TXF - 1));
        rd(8'h04, d); chk("R4 push with pop on full dropped", d, 16'h0001);
        for (int n = 1; n < DEPTH; n++) begin
            rd(TX_POP, d); chk("R4 tx remaining order", d, txw(n, TXF - 1));
        end
        rd(8'h00, d); chk("R4 tx empty after drop", d, 16'h0000);
        wr(8'h04, 16'h0001);
    endtask

    task automatic t_empty_pop();
        logic [15:0] d;
        rd(TX_POP, d); chk("R5 empty tx pop", d, 16'h0000);
        rd(TX_POP, d); chk("R5 empty tx pop again", d, 16'h0000);
        push_tx(5);
        rd(8'h20, d); chk("R5 head after empty pop", d, txw(5, 0));
        rd(TX_POP, d); chk("R5 pop after empty pop", d, txw(5, TXF - 1));
        rd(8'h22, d); chk("R5 field read empty", d, 16'h0000);
    endtask

    task automatic t_flags();
        logic [15:0] d;
        pulse(4'b0101);
        rd(8'h00, d); chk("R7 event set", d, 16'h0014);
        wr(8'h00, 16'h0004);
        rd(8'h00, d); chk("R7 w1c bit2", d, 16'h0010);
        wr(8'h00, 16'h0000);
        rd(8'h00, d); chk("R7 write zero", d, 16'h0010);
        @(negedge clk);
        evt = 4'b0100; bus_addr = 8'h00; bus_wdata = 16'h0010; bus_wr = 1'b1;
        @(negedge clk);
        evt = '0; bus_wr = 1'b0;
        rd(8'h00, d); chk("R7 set beats clear", d, 16'h0010);
        wr(8'h00, 16'h003C);
        rd(8'h00, d); chk("R7 all cleared", d, 16'h0000);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        wr(8'h02, 16'h0004);
        rd(8'h02, d); chk("R8 mask readback", d, 16'h0004);
        pulse(4'b0010);
        chk("R8 masked flag no irq", {15'd0, irq}, 16'h0000);
        pulse(4'b0001);
        chk("R8 unmasked flag irq", {15'd0, irq}, 16'h0001);
        wr(8'h00, 16'h000C);
        chk("R8 irq after clear", {15'd0, irq}, 16'h0000);
        wr(8'h02, 16'h0001);
        push_tx(3);
        chk("R8 irq from tx pending", {15'd0, irq}, 16'h0001);
        rd(TX_POP, d);
        chk("R8 irq after tx drain", {15'd0, irq}, 16'h0000);
        rd(8'h06, d); chk("R9 unused control offset", d, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_order();
        t_rx_overflow();
        t_empty_pop();
        t_flags();
        t_irq();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule